// File: doc/BRIEF.md
# Byte-Bus Loader for a 12-Bit DAC Input Register

This block lets an 8-bit processor write bus set a 12-bit converter code in two byte writes. Two decoded write addresses share one chip select and one write strobe, both active low. A write to the upper address captures the low four bus bits in a side nibble latch. A write to the lower address opens the converter input register, which then takes the held nibble as bits 11 to 8 and the bus byte as bits 7 to 0.

The converter register is modelled as a level-sensitive register sampled on the clock. While chip select and write are both low at the lower address, it is reloaded on every clock edge, so it follows the bus. As soon as either strobe goes high it closes and keeps the last value it took. Software is expected to write the nibble first and the byte second, so the full code reaches the converter in one update. The strobe must be timed by the bus logic so that it is low only while bus data is valid.

A format input chooses straight binary or two's complement. In two's-complement format the code MSB is inverted as it is loaded, which turns the input into offset binary for a bipolar output stage. A one-clock valid pulse marks the point where the register closes after a byte write.

Top module: `byte_dac_loader`

## Requirements
- R1: With `rst` high at a clock edge, `dac_code`, `code_valid` and the nibble latch are cleared to 0. A byte write with nothing else changed then yields `dac_code[11:8]` = 0.
- R2: A nibble write is a cycle with `ld_cs_n`=0, `ld_wr_n`=0 and `ld_addr`=1. It stores `ld_data[3:0]` in the nibble latch one edge later. `ld_data[7:4]` are ignored, and `dac_code` does not change.
- R3: A byte write is a cycle with `ld_cs_n`=0, `ld_wr_n`=0 and `ld_addr`=0. After the next edge, `dac_code[7:0]` equals that cycle's `ld_data` and `dac_code[11:8]` equals the nibble latch. Over a multi-cycle write the code follows the bus on every cycle.
- R4: In any cycle with `ld_cs_n`=1 or `ld_wr_n`=1, `dac_code` keeps its value across the next edge, whatever `ld_data`, `ld_addr` and `fmt_twos` are.
- R5: `code_valid` is high for exactly one cycle. It is high only after the first edge that follows the last cycle of a byte write. Nibble writes never raise it, and a run of back-to-back byte-write cycles raises it once.
- R6: With `fmt_twos`=1 during a byte write, `dac_code[11]` is loaded as the inverse of nibble bit 3. With `fmt_twos`=0 it is loaded unchanged. Bits 10 to 0 are never inverted. `fmt_twos` matters only in byte-write cycles.
- R7: The nibble latch keeps its value across any number of byte writes and idle cycles until the next nibble write.
- R8: At most one of the two address decodes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_cs_n | input | 1 | Chip select, active low |
| ld_wr_n | input | 1 | Write strobe, active low, timed to valid data |
| ld_addr | input | 1 | Address select: 1 = nibble latch, 0 = byte and converter register |
| ld_data | input | 8 | Processor data bus |
| fmt_twos | input | 1 | 1 = two's-complement input (MSB inverted), 0 = straight binary |
| dac_code | output | 12 | Code driven to the converter |
| code_valid | output | 1 | One-clock pulse when the converter register closes |

## Verification
A wrong nibble latch stays hidden until the next byte write. The bench therefore follows every nibble write with byte writes and checks bits 11 to 8 one clock after each of them. A register that fails to hold, or that responds to a nibble write, shows as a changed `dac_code` on the very next edge. The bench compares the code on every cycle, so the error is caught there. A wrong open/closed flag moves or doubles the `code_valid` pulse, and the bench sees it one edge after the strobe is released. A wrong format path flips only bit 11, and only in two's-complement byte writes; random format values together with directed codes on both sides of the MSB expose it.

// File: rtl/byte_dac_pkg.sv
package byte_dac_pkg;
    typedef enum logic {
        FMT_BINARY = 1'b0,
        FMT_TWOS   = 1'b1
    } code_fmt_e;
endpackage

// File: rtl/bdl_decode.sv
module bdl_decode (
    input  logic cs_n,
    input  logic wr_n,
    input  logic addr,
    output logic hit_nib,
    output logic hit_byte
);
    logic strobe;

    always_comb begin
        strobe   = ~cs_n & ~wr_n;
        hit_nib  = strobe &  addr;
        hit_byte = strobe & ~addr;
    end

    always_comb begin
        AST_ONE_DECODE: assert ($onehot0({hit_nib, hit_byte})); // R8
    end
endmodule

// File: rtl/bdl_format.sv
module bdl_format
    import byte_dac_pkg::*;
#(
    parameter int HI_W     = 4,
    parameter int LO_W     = 8,
    parameter bit HAS_TWOS = 1'b1,
    localparam int CODE_W  = HI_W + LO_W
) (
    input  logic [HI_W-1:0]   nib,
    input  logic [LO_W-1:0]   low_byte,
    input  logic              fmt,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] raw;

    always_comb raw = {nib, low_byte};

    generate
        if (HAS_TWOS) begin : g_twos
            always_comb begin
                code = raw;
                if (code_fmt_e'(fmt) == FMT_TWOS)
                    code[CODE_W-1] = ~raw[CODE_W-1];
            end
        end else begin : g_plain
            always_comb code = raw;
        end
    endgenerate
endmodule

// File: rtl/byte_dac_loader.sv
module byte_dac_loader #(
    parameter int HI_W     = 4,
    parameter int LO_W     = 8,
    parameter bit HAS_TWOS = 1'b1,
    localparam int CODE_W  = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_cs_n,
    input  logic              ld_wr_n,
    input  logic              ld_addr,
    input  logic [LO_W-1:0]   ld_data,
    input  logic              fmt_twos,
    output logic [CODE_W-1:0] dac_code,
    output logic              code_valid
);
    typedef struct packed {
        logic [HI_W-1:0]   nib;
        logic [CODE_W-1:0] code;
        logic              open;
        logic              valid;
    } state_t;

    state_t st_d, st_q;
    logic hit_nib, hit_byte;
    logic [CODE_W-1:0] fmt_code;

    bdl_decode u_dec (
        .cs_n     (ld_cs_n),
        .wr_n     (ld_wr_n),
        .addr     (ld_addr),
        .hit_nib  (hit_nib),
        .hit_byte (hit_byte)
    );

    bdl_format #(
        .HI_W     (HI_W),
        .LO_W     (LO_W),
        .HAS_TWOS (HAS_TWOS)
    ) u_fmt (
        .nib      (st_q.nib),
        .low_byte (ld_data),
        .fmt      (fmt_twos),
        .code     (fmt_code)
    );

    always_comb begin
        st_d = st_q;
        if (hit_nib)
            st_d.nib = ld_data[HI_W-1:0];
        if (hit_byte)
            st_d.code = fmt_code;
        st_d.open  = hit_byte;
        st_d.valid = st_q.open & ~hit_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dac_code   = st_q.code;
    assign code_valid = st_q.valid;

    AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !hit_byte |=> $stable(dac_code)); // R4
    AST_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        hit_byte |=> dac_code[LO_W-1:0] == $past(ld_data)); // R3
    AST_MSB_FORMAT: assert property (@(posedge clk) disable iff (rst)
        hit_byte |=> dac_code[CODE_W-1] ==
            ($past(st_q.nib[HI_W-1]) ^ (HAS_TWOS & $past(fmt_twos)))); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid); // R5
    AST_NO_VALID_OPEN: assert property (@(posedge clk) disable iff (rst)
        hit_byte |=> !code_valid); // R5
    AST_NIB_KEPT: assert property (@(posedge clk) disable iff (rst)
        !hit_nib |=> $stable(st_q.nib)); // R7
endmodule

// File: tb/tb_byte_dac_loader.sv
module tb_byte_dac_loader;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_cs_n, ld_wr_n, ld_addr, fmt_twos;
    logic [7:0]  ld_data;
    logic [11:0] dac_code;
    logic        code_valid;

    int n_run  = 0;
    int n_fail = 0;

    logic [3:0]  m_nib;
    logic [11:0] m_code;
    logic        m_open, m_valid;
    string       m_tag;

    always #4 clk = ~clk;

    byte_dac_loader dut (
        .clk(clk), .rst(rst), .ld_cs_n(ld_cs_n), .ld_wr_n(ld_wr_n),
        .ld_addr(ld_addr), .ld_data(ld_data), .fmt_twos(fmt_twos),
        .dac_code(dac_code), .code_valid(code_valid)
    );

    function automatic logic [11:0] exp_code(input logic [3:0] n,
                                             input logic [7:0] b,
                                             input logic t);
        logic [11:0] c;
        c = {n, b};
        c[11] = c[11] ^ t;
        return c;
    endfunction

    // Compare outputs (at negedge) with the model, then apply inputs and advance the model.
    task automatic cyc(input logic r, input logic cs, input logic wr,
                       input logic a, input logic [7:0] d, input logic t);
        @(negedge clk);
        n_run++;
        if (dac_code !== m_code) begin
            n_fail++;
            $display("FAIL %s dac_code: actual %h expected %h", m_tag, dac_code, m_code);
        end
        n_run++;
        if (code_valid !== m_valid) begin
            n_fail++;
            $display("FAIL R5 code_valid (%s): actual %b expected %b", m_tag, code_valid, m_valid);
        end
        rst = r; ld_cs_n = cs; ld_wr_n = wr; ld_addr = a; ld_data = d; fmt_twos = t;
        if (r) begin
            m_nib = '0; m_code = '0; m_open = 0; m_valid = 0; m_tag = "R1";
        end else begin
            logic hb, hn;
            hb = !cs && !wr && !a;
            hn = !cs && !wr && a;
            m_valid = m_open && !hb;
            m_open  = hb;
            if (hb) begin
                m_code = exp_code(m_nib, d, t);
                m_tag = t ? "R6" : "R3";
            end else if (hn) begin
                m_nib = d[3:0];
                m_tag = "R2";
            end else begin
                m_tag = "R4";
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; ld_cs_n = 1; ld_wr_n = 1; ld_addr = 0; ld_data = 0; fmt_twos = 0;
        m_nib = 0; m_code = 0; m_open = 0; m_valid = 0; m_tag = "R1";
        @(posedge clk);
        cyc(1, 1, 1, 0, 8'h00, 0);
        cyc(0, 1, 1, 0, 8'h00, 0);               // R1 reset state
        cyc(0, 0, 0, 0, 8'h5A, 0);               // R1 nibble is 0
        cyc(0, 1, 1, 0, 8'hFF, 1);               // R5 pulse next
        cyc(0, 1, 1, 0, 8'h00, 0);
        // R2: upper data bits ignored; code unchanged
        cyc(0, 0, 0, 1, 8'hF3, 0);
        cyc(0, 1, 1, 1, 8'h00, 0);
        cyc(0, 0, 0, 0, 8'hC1, 0);               // R3 expects 3C1
        cyc(0, 1, 1, 0, 8'h00, 0);
        // R3: multi-cycle write follows bus; R5 single pulse
        cyc(0, 0, 0, 0, 8'h11, 0);
        cyc(0, 0, 0, 0, 8'h22, 0);
        cyc(0, 0, 0, 0, 8'h33, 0);
        cyc(0, 1, 0, 0, 8'h44, 0);               // R4 cs high
        cyc(0, 0, 1, 0, 8'h55, 1);               // R4 wr high
        cyc(0, 1, 1, 0, 8'h66, 1);
        // R6 two's complement on both MSB values
        cyc(0, 0, 0, 1, 8'h08, 0);
        cyc(0, 0, 0, 0, 8'h00, 1);               // 800 -> 000
        cyc(0, 1, 1, 0, 8'h00, 1);
        cyc(0, 0, 0, 1, 8'h07, 1);
        cyc(0, 0, 0, 0, 8'hFF, 1);               // 7FF -> FFF
        cyc(0, 1, 1, 0, 8'h00, 0);
        // R7 nibble persists
        cyc(0, 0, 0, 0, 8'h12, 0);
        cyc(0, 1, 1, 0, 8'h00, 0);
        cyc(0, 0, 0, 0, 8'h34, 0);
        cyc(0, 1, 1, 0, 8'h00, 0);
        // random mix with a fixed seed
        void'($urandom(32'd7));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[31:28] == 4'hF && r[27], r[0] & r[1], r[2] & r[3], r[4],
                r[15:8], r[5]);
        end
        cyc(0, 1, 1, 0, 8'h00, 0);
        cyc(0, 1, 1, 0, 8'h00, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule